// File: doc/BRIEF.md
# Host Serial Control and Readout Port

A small clocked serial port on the host side of a digital audio receiver. A host microcontroller frames each transfer with a strobe and clocks bits in on a serial data line. The first eight bits are an address, sent least significant bit first. A command-write address takes eight more bits into the control word. The control word drives four decoded fields: system halt, demodulator input choice, auxiliary pin source and audio output format. A read address takes a snapshot of either the channel-status word or the subcode-Q word. That snapshot then goes out on the read line, one bit per serial clock.

A map-select input chooses between two address maps. The same input sets how the read line is driven. With map 0 the line behaves as open-drain: it pulls low only for zero bits and otherwise relies on an external pull-up. With map 1 it is three-state and driven for the whole read. The serial inputs are resynchronised into the system clock domain, so the serial clock must be several system clocks slower. Filling the channel-status and subcode words is done outside this block.

Top module: `host_port`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, every control output is cleared to 0 and `hp_sdo_drive` is low.
- R2: With `map_sel`=0, address 0xF7 is the command write, 0xF8 is the channel-status read and 0xF9 is the subcode-Q read. The address is taken from the first eight rising `hp_sck` edges of a frame, least significant bit first.
- R3: With `map_sel`=1, address 0xEA is the command write, 0xE9 is the channel-status read and 0xE8 is the subcode-Q read.
- R4: The command byte is the eight bits that follow the address, bit 0 first. `sys_stop` takes bit 1 and `in_sel` takes bit 2. `aux_sel[1]` takes bit 3 and `aux_sel[0]` takes bit 4. `fmt_sel[1]` takes bit 5 and `fmt_sel[0]` takes bit 6. Bits 0 and 7 change no output.
- R5: The control outputs change only when `hp_stb` falls after exactly 16 rising `hp_sck` edges in a write frame. A frame with 15 or 17 edges leaves them unchanged.
- R6: A frame whose address is not the write address of the selected map leaves the control outputs unchanged. This includes a read address and the other map's write address.
- R7: A channel-status read with `map_sel`=0 returns `cs_word` bit 0 first, 32 bits. Each bit appears after a falling `hp_sck` edge. The first bit appears after the falling edge that follows the eighth address bit.
- R8: A channel-status read with `map_sel`=1 returns a 1 first, then the 32 `cs_word` bits, bit 0 first.
- R9: A subcode-Q read returns `sq_crc_ok` first, then the 80 `sq_word` bits, bit 0 first, in either map.
- R10: With `map_sel`=0, `hp_sdo_drive` is high only during a read and only for 0 bits, and `hp_sdo_val` is then 0. With `map_sel`=1, `hp_sdo_drive` is high from address decode until `hp_stb` falls, and `hp_sdo_val` is the bit.
- R11: After all snapshot bits have gone out, further read bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sel | input | 1 | Address map and read-line driver style |
| hp_sck | input | 1 | Host serial clock |
| hp_stb | input | 1 | Host frame strobe, high during a transfer |
| hp_sdi | input | 1 | Host serial data in |
| cs_word | input | 32 | Channel-status word to read |
| sq_word | input | 80 | Subcode-Q word to read |
| sq_crc_ok | input | 1 | Subcode-Q check result |
| hp_sdo_val | output | 1 | Read line value while driven |
| hp_sdo_drive | output | 1 | Read line output enable |
| sys_stop | output | 1 | Halt request |
| in_sel | output | 1 | Demodulator input choice |
| aux_sel | output | 2 | Auxiliary pin source |
| fmt_sel | output | 2 | Audio output format |

## Verification
A wrong bit count or a missed address decode shows up at the control outputs one strobe later. Either the fields fail to take the new byte, or a short or long frame updates them when it should not. A skipped or doubled shift in the readout register moves every following bit by one position. That error appears on the read line at the very first host sample after the address. Wrong driver-style logic shows as a drive enable that is high during an idle frame, or high for a 1 bit with map 0.

// File: rtl/hp_pkg.sv
// Package: shared types and address decode for the host serial port.
// Assumes 8-bit addresses; map 0 and map 1 carry distinct address triples.
package hp_pkg;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_WRITE = 2'd1,
        XF_RD_CS = 2'd2,
        XF_RD_SQ = 2'd3
    } xfer_kind_t;

    localparam logic [7:0] M0_WR = 8'hF7;
    localparam logic [7:0] M0_CS = 8'hF8;
    localparam logic [7:0] M0_SQ = 8'hF9;
    localparam logic [7:0] M1_WR = 8'hEA;
    localparam logic [7:0] M1_CS = 8'hE9;
    localparam logic [7:0] M1_SQ = 8'hE8;

    // Map a received address to a transfer kind under the selected map.
    function automatic xfer_kind_t decode_addr(input logic map1, input logic [7:0] a);
        xfer_kind_t k;
        k = XF_NONE;
        if (!map1) begin
            if (a == M0_WR)      k = XF_WRITE;
            else if (a == M0_CS) k = XF_RD_CS;
            else if (a == M0_SQ) k = XF_RD_SQ;
        end else begin
            if (a == M1_WR)      k = XF_WRITE;
            else if (a == M1_CS) k = XF_RD_CS;
            else if (a == M1_SQ) k = XF_RD_SQ;
        end
        return k;
    endfunction

endpackage

// File: rtl/hp_sync.sv
// Module: resynchronises N asynchronous serial inputs and flags their edges.
// Assumes each input holds every level for more than STAGES+1 clocks.
module hp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;
            // Shift the input through the synchroniser chain and keep last level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                    prev  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[g]};
                    prev  <= chain[STAGES-1];
                end
            end
            assign lvl[g]  = chain[STAGES-1];
            assign rise[g] = chain[STAGES-1] & ~prev;
            assign fall[g] = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/hp_frame.sv
// Module: frame sequencer. Counts serial clock rises inside a strobe frame,
// assembles the address and command byte and decodes the transfer kind.
// Assumes strobe and clock edges arrive as single-cycle pulses.
module hp_frame
    import hp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CMD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_sel,
    input  logic             stb_lvl,
    input  logic             stb_rise,
    input  logic             stb_fall,
    input  logic             sck_rise,
    input  logic             sdi,
    output logic             commit,
    output logic [CMD_W-1:0] cmd_byte,
    output logic             load,
    output xfer_kind_t       kind,
    output logic             reading
);
    localparam int FRAME_W = ADDR_W + CMD_W;
    localparam int CNT_W   = $clog2(FRAME_W) + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_sr;
    logic [CMD_W-1:0]  data_sr;
    logic [ADDR_W-1:0] addr_next;

    assign addr_next = {sdi, addr_sr[ADDR_W-1:1]};

    // Count clock rises, assemble fields and decode at the last address bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            kind    <= XF_NONE;
            reading <= 1'b0;
            load    <= 1'b0;
        end else begin
            load <= 1'b0;
            if (stb_rise) begin
                cnt     <= '0;
                kind    <= XF_NONE;
                reading <= 1'b0;
            end else if (!stb_lvl) begin
                reading <= 1'b0;
            end else if (sck_rise) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (cnt < CNT_W'(ADDR_W)) addr_sr <= addr_next;
                if (cnt == CNT_W'(ADDR_W - 1)) begin
                    kind <= decode_addr(map_sel, addr_next);
                    if (decode_addr(map_sel, addr_next) inside {XF_RD_CS, XF_RD_SQ}) begin
                        load    <= 1'b1;
                        reading <= 1'b1;
                    end
                end
                if (cnt >= CNT_W'(ADDR_W) && cnt < CNT_W'(FRAME_W))
                    data_sr <= {sdi, data_sr[CMD_W-1:1]};
            end
        end
    end

    // Issue a one-cycle commit when a complete write frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit   <= 1'b0;
            cmd_byte <= '0;
        end else begin
            commit   <= stb_fall && kind == XF_WRITE && cnt == CNT_W'(FRAME_W);
            cmd_byte <= data_sr;
        end
    end

    // R5
    commit_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stb_fall));
    // R2
    load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(sck_rise) && reading);
    // R5
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, load}));
endmodule

// File: rtl/hp_cmd.sv
// Module: command register. Holds the control byte and splits it into fields.
// Assumes commit is a single-cycle pulse carrying a complete byte.
module hp_cmd #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic             sys_stop,
    output logic             in_sel,
    output logic [1:0]       aux_sel,
    output logic [1:0]       fmt_sel
);
    logic [5:0] fields;

    // Load the used command bits on commit; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fields <= '0;
        else if (commit)
            fields <= {cmd_byte[1], cmd_byte[2], cmd_byte[3], cmd_byte[4],
                       cmd_byte[5], cmd_byte[6]};
    end

    assign sys_stop = fields[5];
    assign in_sel   = fields[4];
    assign aux_sel  = fields[3:2];
    assign fmt_sel  = fields[1:0];

    // R5
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(fields));
endmodule

// File: rtl/hp_readout.sv
// Module: readout shifter. Snapshots the selected word at decode and shifts
// it out one bit per serial clock fall, filling with ones behind it.
// Assumes load never coincides with a serial clock fall.
module hp_readout
    import hp_pkg::*;
#(
    parameter int CS_W = 32,
    parameter int SQ_W = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            map_sel,
    input  logic            load,
    input  xfer_kind_t      kind,
    input  logic            reading,
    input  logic            sck_fall,
    input  logic [CS_W-1:0] cs_word,
    input  logic [SQ_W-1:0] sq_word,
    input  logic            sq_crc_ok,
    output logic            bit_out
);
    localparam int RO_W = (CS_W + 1 > SQ_W + 1) ? CS_W + 1 : SQ_W + 1;

    logic [RO_W-1:0] shreg;
    logic [RO_W-1:0] snap;

    // Build the snapshot for the decoded read kind and map.
    always_comb begin
        snap = '1;
        if (kind == XF_RD_SQ) begin
            snap[SQ_W:1] = sq_word;
            snap[0]      = sq_crc_ok;
        end else if (map_sel) begin
            snap[CS_W:1] = cs_word;
            snap[0]      = 1'b1;
        end else begin
            snap[CS_W-1:0] = cs_word;
        end
    end

    // Load at decode, then present one bit per falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '1;
            bit_out <= 1'b1;
        end else if (load) begin
            shreg <= snap;
        end else if (!reading) begin
            bit_out <= 1'b1;
        end else if (sck_fall) begin
            bit_out <= shreg[0];
            shreg   <= {1'b1, shreg[RO_W-1:1]};
        end
    end

    // R11
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && !load) |=> bit_out);
endmodule

// File: rtl/host_port.sv
// Module: host serial control and readout port (top).
// Assumes hp_sck, hp_stb and hp_sdi are slower than clk by several cycles.
module host_port #(
    parameter int ADDR_W      = 8,
    parameter int CMD_W       = 8,
    parameter int CS_W        = 32,
    parameter int SQ_W        = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            map_sel,
    input  logic            hp_sck,
    input  logic            hp_stb,
    input  logic            hp_sdi,
    input  logic [CS_W-1:0] cs_word,
    input  logic [SQ_W-1:0] sq_word,
    input  logic            sq_crc_ok,
    output logic            hp_sdo_val,
    output logic            hp_sdo_drive,
    output logic            sys_stop,
    output logic            in_sel,
    output logic [1:0]      aux_sel,
    output logic [1:0]      fmt_sel
);
    import hp_pkg::*;

    logic [2:0]       s_lvl, s_rise, s_fall;
    logic             commit, load, reading, bit_out;
    logic [CMD_W-1:0] cmd_byte;
    xfer_kind_t       kind;

    hp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({hp_sdi, hp_stb, hp_sck}),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    hp_frame #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
        .stb_lvl(s_lvl[1]), .stb_rise(s_rise[1]), .stb_fall(s_fall[1]),
        .sck_rise(s_rise[0]), .sdi(s_lvl[2]),
        .commit(commit), .cmd_byte(cmd_byte), .load(load),
        .kind(kind), .reading(reading)
    );

    hp_cmd #(.CMD_W(CMD_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmd_byte(cmd_byte),
        .sys_stop(sys_stop), .in_sel(in_sel), .aux_sel(aux_sel), .fmt_sel(fmt_sel)
    );

    hp_readout #(.CS_W(CS_W), .SQ_W(SQ_W)) u_ro (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .load(load), .kind(kind),
        .reading(reading), .sck_fall(s_fall[0]), .cs_word(cs_word),
        .sq_word(sq_word), .sq_crc_ok(sq_crc_ok), .bit_out(bit_out)
    );

    // Pick the driver style from the map: open-drain low pulls or full drive.
    always_comb begin
        hp_sdo_val   = bit_out;
        hp_sdo_drive = map_sel ? reading : (reading & ~bit_out);
    end

    // R10
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_sel && hp_sdo_drive) |-> !hp_sdo_val);
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_lvl[1] |=> !hp_sdo_drive);
endmodule

// File: tb/host_port_test.sv
module host_port_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sel = 1'b0;
    logic        hp_sck = 1'b0, hp_stb = 1'b0, hp_sdi = 1'b0;
    logic [31:0] cs_word = 32'h0;
    logic [79:0] sq_word = 80'h0;
    logic        sq_crc_ok = 1'b0;
    logic        hp_sdo_val, hp_sdo_drive, sys_stop, in_sel;
    logic [1:0]  aux_sel, fmt_sel;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    host_port uut (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .hp_sck(hp_sck),
        .hp_stb(hp_stb), .hp_sdi(hp_sdi), .cs_word(cs_word), .sq_word(sq_word),
        .sq_crc_ok(sq_crc_ok), .hp_sdo_val(hp_sdo_val), .hp_sdo_drive(hp_sdo_drive),
        .sys_stop(sys_stop), .in_sel(in_sel), .aux_sel(aux_sel), .fmt_sel(fmt_sel)
    );

    // {map, addr, data, nbits, expected {stop,in,aux1,aux0,fmt1,fmt0}}
    typedef struct packed {
        logic       m;
        logic [7:0] a;
        logic [7:0] d;
        logic [4:0] n;
        logic [5:0] e;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b0, 8'hF7, 8'h02, 5'd16, 6'b100000},
        '{1'b0, 8'hF7, 8'hFF, 5'd16, 6'b111111},
        '{1'b0, 8'hF7, 8'h81, 5'd16, 6'b000000},
        '{1'b0, 8'hF7, 8'h08, 5'd16, 6'b001000},
        '{1'b0, 8'hF7, 8'h10, 5'd15, 6'b001000},
        '{1'b0, 8'hF7, 8'h10, 5'd17, 6'b001000},
        '{1'b0, 8'hEA, 8'h7E, 5'd16, 6'b001000},
        '{1'b0, 8'hF8, 8'h7E, 5'd16, 6'b001000},
        '{1'b1, 8'hEA, 8'h10, 5'd16, 6'b000100},
        '{1'b1, 8'hEA, 8'h20, 5'd16, 6'b000010},
        '{1'b1, 8'hEA, 8'h44, 5'd16, 6'b010001},
        '{1'b1, 8'hF7, 8'h02, 5'd16, 6'b010001},
        '{1'b0, 8'hF7, 8'h00, 5'd16, 6'b000000}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        hp_sdi = b;
        wait_n(HALF);
        hp_sck = 1'b1;
        wait_n(HALF);
        hp_sck = 1'b0;
    endtask

    task automatic frame_open();
        hp_stb = 1'b1;
        wait_n(HALF);
    endtask

    task automatic frame_close();
        wait_n(HALF);
        hp_stb = 1'b0;
        wait_n(2 * HALF);
    endtask

    task automatic send_frame(input logic [16:0] w, input int n);
        frame_open();
        for (int i = 0; i < n; i++) clk_bit(w[i]);
        frame_close();
    endtask

    // Read n bits; each sampled late in the low half before the host rise.
    task automatic read_bits(input string req, input int n, input logic [127:0] exp, input logic m1);
        for (int i = 0; i < n; i++) begin
            logic line;
            wait_n(HALF - 1);
            line = hp_sdo_drive ? hp_sdo_val : 1'b1;
            check(req, {127'h0, line}, {127'h0, exp[i]});
            if (m1) check("R10 drive", {127'h0, hp_sdo_drive}, 128'h1);
            else    check("R10 drive", {127'h0, hp_sdo_drive}, {127'h0, ~exp[i]});
            @(negedge clk);
            hp_sck = 1'b1;
            wait_n(HALF);
            hp_sck = 1'b0;
        end
    endtask

    task automatic read_frame(input string req, input logic m, input logic [7:0] a,
                              input int n, input logic [127:0] exp);
        map_sel = m;
        frame_open();
        for (int i = 0; i < 8; i++) clk_bit(a[i]);
        read_bits(req, n, exp, m);
        frame_close();
        check("R10 released", {127'h0, hp_sdo_drive}, 128'h0);
    endtask

    function automatic logic [127:0] fields();
        return {122'h0, sys_stop, in_sel, aux_sel, fmt_sel};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        wait_n(4);
        // R1 reset state
        check("R1 fields", fields(), 128'h0);
        check("R1 drive", {127'h0, hp_sdo_drive}, 128'h0);
        rst_n = 1'b1;
        wait_n(4);

        // R2 R3 R4 R5 R6 via the vector table
        for (int v = 0; v < 13; v++) begin
            map_sel = VECS[v].m;
            send_frame({1'b0, VECS[v].d, VECS[v].a}, int'(VECS[v].n));
            check($sformatf("R2/R3/R4/R5/R6 vec %0d", v), fields(), {122'h0, VECS[v].e});
        end

        // R1 reset after a full write
        map_sel = 1'b0;
        send_frame({1'b0, 8'hFF, 8'hF7}, 16);
        check("R4 all set", fields(), {122'h0, 6'b111111});
        @(negedge clk); rst_n = 1'b0;
        wait_n(2);
        check("R1 reset clears", fields(), 128'h0);
        rst_n = 1'b1;
        wait_n(4);

        // R7 R11 map 0 channel status, two trailing ones
        cs_word = 32'hA5C3_0F96;
        check("R10 idle", {127'h0, hp_sdo_drive}, 128'h0);
        read_frame("R7/R11 cs map0", 1'b0, 8'hF8, 34, {94'h0, 2'b11, 32'hA5C3_0F96});

        // R8 map 1 channel status with leading flag
        cs_word = 32'h1234_8765;
        read_frame("R8 cs map1", 1'b1, 8'hE9, 34, {93'h0, 1'b1, 32'h1234_8765, 1'b1});

        // R9 subcode with failing check flag, map 0
        sq_word = 80'h0123_4567_89AB_CDEF_F00D;
        sq_crc_ok = 1'b0;
        read_frame("R9 sq map0", 1'b0, 8'hF9, 81, {47'h0, 80'h0123_4567_89AB_CDEF_F00D, 1'b0});

        // R9 subcode with passing flag, map 1
        sq_word = 80'hFEDC_0000_1111_2222_8001;
        sq_crc_ok = 1'b1;
        read_frame("R9 sq map1", 1'b1, 8'hE8, 81, {47'h0, 80'hFEDC_0000_1111_2222_8001, 1'b1});

        // R6 reads left the command register alone
        check("R6 after reads", fields(), 128'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule